// File: doc/BRIEF.md
# Two-Step Refresh Software Watchdog

This block is a software-serviced watchdog for a small microcontroller. A 16-bit up-counter advances once per prescaler period, and the period is either 24 or 384 system clocks. When the count reaches the trip value 0x7CFF, the block raises a registered reset-request output and sets a sticky status bit. The status bit stands for the watchdog flag in the interrupt-priority register. The chip-level reset generator, the processor and the register-bus decoder are outside the block.

Software drives the block through two one-cycle strobes and an 8-bit reload register. The go strobe starts an idle watchdog. After that, only the internal reset can stop it. To service the watchdog, software first issues the arm strobe and then the go strobe no more than 12 cycles later. The counter is then reloaded from the reload register, and the prescaler restarts. An arm strobe that is not followed in time expires without any effect. A go strobe with no armed step does nothing to a running counter.

Top module: `wdg_two_step`

## Requirements
- R1: While reset is active and just after it is released, count_o is 0x0000, rst_req_o is 0 and prio_flag_o is 0, and the watchdog is idle.
- R2: While the watchdog is idle, the counter does not change. A go strobe in the idle state starts the watchdog without loading the counter.
- R3: When reload bit 7 is 0, the count increments once every 24 clocks. The first increment comes 24 cycles after the start edge or the reload edge.
- R4: When reload bit 7 is 1, the count increments once every 384 clocks.
- R5: Once the watchdog runs, it keeps counting. Further go strobes cannot stop it; only reset can.
- R6: rst_req_o is high exactly in the cycles in which count_o holds 0x7CFF. It drops as soon as the count moves on.
- R7: prio_flag_o sets in the same cycle that rst_req_o first goes high. It stays set until reset.
- R8: If a go strobe is sampled 1 to 12 cycles after an arm strobe, the counter loads {0, reload[6:0], 0x00} on that edge.
- R9: If 12 cycles pass after an arm strobe with no go strobe, the armed step is discarded. A go strobe at 13 cycles or later does not reload.
- R10: A go strobe with no armed step leaves a running counter unaffected.
- R11: Every reload restarts the prescaler. The next increment comes one full period after the reload edge.
- R12: The count wraps from 0xFFFF to 0x0000 on the next increment.
- R13: A write to the reload register takes effect in the next cycle. Its bit 7 selects the prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rel_we_i | input | 1 | Write strobe for the reload register |
| rel_wdata_i | input | 8 | Reload write data: bit 7 is the prescaler select, bits 6:0 are the count image |
| arm_stb_i | input | 1 | One-cycle first step of a refresh |
| go_stb_i | input | 1 | One-cycle start strobe, and the second step of a refresh |
| rst_req_o | output | 1 | Reset request, high while the count is 0x7CFF |
| prio_flag_o | output | 1 | Sticky watchdog status bit |
| count_o | output | 16 | Counter readback |

## Verification
Every result is due a fixed number of edges after its stimulus. A reload appears on count_o at the edge that samples the go strobe. An increment appears 24 or 384 edges after the start edge or reload edge. rst_req_o and prio_flag_o change at the same edge as the count that causes them. The bench drives and samples on the falling edge, stamps each reload edge with a free-running edge counter, and predicts the count as the reload image plus the elapsed edges divided by the period. Windows of 12 and 13 cycles, the cycle before each increment, and the cycle before the trip value are all sampled directly.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned WDG_CNT_W      = 16;
  localparam int unsigned WDG_REL_W      = 8;
  localparam int unsigned WDG_BASE_DIV   = 12;
  localparam int unsigned WDG_FINE_DIV   = 2;
  localparam int unsigned WDG_COARSE_DIV = 16;
  localparam int unsigned WDG_WIN_CYC    = 12;
  localparam int unsigned WDG_TRIP       = 32'h7CFF;

  typedef enum logic {
    PS_FAST = 1'b0,
    PS_SLOW = 1'b1
  } ps_sel_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned BASE_DIV   = 12,
  parameter int unsigned FINE_DIV   = 2,
  parameter int unsigned COARSE_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned FW = (FINE_DIV > 1) ? $clog2(FINE_DIV) : 1;
  localparam int unsigned CW = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;

  logic          base_wrap;
  logic          fine_wrap;
  logic          coarse_wrap;
  logic [FW-1:0] fine_q, fine_d;
  logic [CW-1:0] coarse_q, coarse_d;

  generate
    if (BASE_DIV > 1) begin : g_base
      localparam int unsigned BW = $clog2(BASE_DIV);
      logic [BW-1:0] base_q, base_d;
      assign base_wrap = (base_q == BW'(BASE_DIV - 1));
      always_comb begin
        base_d = base_q;
        if (clr_i)     base_d = '0;
        else if (en_i) base_d = base_wrap ? '0 : base_q + BW'(1);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) base_q <= '0;
        else         base_q <= base_d;
      end
    end else begin : g_nobase
      assign base_wrap = 1'b1;
    end
  endgenerate

  assign fine_wrap   = base_wrap && (fine_q == FW'(FINE_DIV - 1));
  assign coarse_wrap = fine_wrap && (coarse_q == CW'(COARSE_DIV - 1));

  always_comb begin
    fine_d   = fine_q;
    coarse_d = coarse_q;
    if (clr_i) begin
      fine_d   = '0;
      coarse_d = '0;
    end else if (en_i) begin
      if (base_wrap) fine_d   = fine_wrap ? '0 : fine_q + FW'(1);
      if (fine_wrap) coarse_d = coarse_wrap ? '0 : coarse_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else begin
      fine_q   <= fine_d;
      coarse_q <= coarse_d;
    end
  end

  assign tick_o = en_i && !clr_i && (slow_i ? coarse_wrap : fine_wrap);

  // R11: the cycle after a restart never carries a tick
  p_clear_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o);
endmodule

// File: rtl/wdg_refresh_window.sv
module wdg_refresh_window #(
  parameter int unsigned WIN_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic go_i,
  input  logic running_i,
  output logic reload_o
);
  localparam int unsigned AW = $clog2(WIN_CYC + 1);

  logic          armed_q, armed_d;
  logic [AW-1:0] age_q, age_d;

  always_comb begin
    armed_d = armed_q;
    age_d   = age_q;
    if (arm_i) begin
      armed_d = 1'b1;
      age_d   = AW'(1);
    end else if (armed_q) begin
      if (go_i || age_q == AW'(WIN_CYC)) begin
        armed_d = 1'b0;
        age_d   = '0;
      end else begin
        age_d = age_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else begin
      armed_q <= armed_d;
      age_q   <= age_d;
    end
  end

  assign reload_o = go_i && armed_q && running_i;

  // R8: an armed step always sits inside the accepted window
  p_age_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (age_q >= AW'(1) && age_q <= AW'(WIN_CYC)));
  // R9: the last window cycle without a re-arm drops the step
  p_expire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && age_q == AW'(WIN_CYC) && !arm_i) |=> !armed_q);
endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TRIP  = 32'h7CFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trip_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trip_q, trip_d;
  logic             flag_q, flag_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (run_i && step_i) cnt_d = cnt_q + CNT_W'(1);
    trip_d = (cnt_d == CNT_W'(TRIP));
    flag_d = flag_q || trip_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign trip_o = trip_q;
  assign flag_o = flag_q;

  // R2: an idle counter holds its value
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
  // R3, R12: each step adds exactly one, modulo the counter width
  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_i && !load_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R6: the request tracks the trip value of the held count
  p_trip_exact_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q == (cnt_q == CNT_W'(TRIP)));
  // R7: the status bit is sticky and covers every request
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q);
  p_flag_covers_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q |-> flag_q);
endmodule

// File: rtl/wdg_two_step.sv
module wdg_two_step
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = WDG_CNT_W,
  parameter int unsigned REL_W      = WDG_REL_W,
  parameter int unsigned BASE_DIV   = WDG_BASE_DIV,
  parameter int unsigned FINE_DIV   = WDG_FINE_DIV,
  parameter int unsigned COARSE_DIV = WDG_COARSE_DIV,
  parameter int unsigned WIN_CYC    = WDG_WIN_CYC,
  parameter int unsigned TRIP       = WDG_TRIP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rel_we_i,
  input  logic [REL_W-1:0] rel_wdata_i,
  input  logic             arm_stb_i,
  input  logic             go_stb_i,
  output logic             rst_req_o,
  output logic             prio_flag_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned LOW_W = CNT_W - REL_W;

  logic             rst_meta_q, rst_sync_q;
  logic [REL_W-1:0] rel_q, rel_d;
  logic             running_q, running_d;
  logic             reload;
  logic             tick;
  logic [CNT_W-1:0] load_img;
  ps_sel_e          ps_sel;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    rel_d     = rel_we_i ? rel_wdata_i : rel_q;
    running_d = running_q || go_stb_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rel_q     <= '0;
      running_q <= 1'b0;
    end else begin
      rel_q     <= rel_d;
      running_q <= running_d;
    end
  end

  assign ps_sel   = ps_sel_e'(rel_q[REL_W-1]);
  assign load_img = {1'b0, rel_q[REL_W-2:0], {LOW_W{1'b0}}};

  wdg_refresh_window #(.WIN_CYC(WIN_CYC)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .arm_i    (arm_stb_i),
    .go_i     (go_stb_i),
    .running_i(running_q),
    .reload_o (reload)
  );

  wdg_prescaler #(
    .BASE_DIV  (BASE_DIV),
    .FINE_DIV  (FINE_DIV),
    .COARSE_DIV(COARSE_DIV)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_sync_q),
    .en_i  (running_q),
    .clr_i (reload),
    .slow_i(ps_sel == PS_SLOW),
    .tick_o(tick)
  );

  wdg_count_core #(.CNT_W(CNT_W), .TRIP(TRIP)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .run_i     (running_q),
    .step_i    (tick),
    .load_i    (reload),
    .load_val_i(load_img),
    .cnt_o     (count_o),
    .trip_o    (rst_req_o),
    .flag_o    (prio_flag_o)
  );

  // R5: once running, only reset stops the watchdog
  p_run_latched_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    running_q |=> running_q);
  // R2: a go strobe in the idle state starts the watchdog
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (!running_q && go_stb_i) |=> running_q);
  // R8: a reload places the register image in the counter
  p_reload_image_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    reload |=> count_o == {1'b0, $past(rel_q[REL_W-2:0]), {LOW_W{1'b0}}});
endmodule

// File: tb/wdg_two_step_tb_top.sv
`timescale 1ns/1ps
module wdg_two_step_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rel_we, arm, go;
  logic [7:0]  rel_wd;
  logic        wdts, prio;
  logic [15:0] cnt;
  logic        w_rel_we, w_arm, w_go;
  logic [7:0]  w_rel_wd;
  logic        w_wdts, w_prio;
  logic [15:0] w_cnt;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  int          cyc_r;
  logic [15:0] base_l;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_two_step dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rel_we_i(rel_we), .rel_wdata_i(rel_wd),
    .arm_stb_i(arm), .go_stb_i(go), .rst_req_o(wdts), .prio_flag_o(prio),
    .count_o(cnt));

  // fast-prescaler copy, used to reach the wrap point in a short run
  wdg_two_step #(.BASE_DIV(1)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .rel_we_i(w_rel_we), .rel_wdata_i(w_rel_wd),
    .arm_stb_i(w_arm), .go_stb_i(w_go), .rst_req_o(w_wdts), .prio_flag_o(w_prio),
    .count_o(w_cnt));

  function automatic logic [15:0] img(input logic [7:0] r);
    return {1'b0, r[6:0], 8'h00};
  endfunction

  function automatic logic [15:0] fast_model(input logic [15:0] b, input int el);
    return b + 16'(el / 24);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_rel(input logic [7:0] v);
    rel_we = 1'b1; rel_wd = v;
    @(negedge clk);
    rel_we = 1'b0;
  endtask

  task automatic pulse_go();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic refresh(input int d);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (d - 1) @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_el(input int el);
    while (cyc - cyc_r < el) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (all R) actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rel_we = 0; arm = 0; go = 0; rel_wd = 0;
    w_rel_we = 0; w_arm = 0; w_go = 0; w_rel_wd = 0;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    check("R1 count in reset", cnt, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 count", cnt, 16'h0);
    check("R1 request", wdts, 1'b0);
    check("R1 flag", prio, 1'b0);

    // R2: idle holds, go starts
    repeat (50) @(negedge clk);
    check("R2 idle hold", cnt, 16'h0);
    pulse_go();
    cyc_r = cyc; base_l = 16'h0;
    wait_el(23);
    check("R3 before first step", cnt, 16'h0);
    wait_el(24);
    check("R3 first step", cnt, 16'h1);
    wait_el(48);
    check("R3 second step", cnt, 16'h2);

    // R5 / R10: go while running, no arm
    pulse_go();
    check("R10 go without arm", cnt, fast_model(base_l, cyc - cyc_r));
    repeat (100) @(negedge clk);
    check("R5 keeps counting", cnt, fast_model(base_l, cyc - cyc_r));

    // R6 / R7: reach the trip value
    write_rel(8'h7C);
    refresh(3);
    cyc_r = cyc;
    check("R8 reload d=3", cnt, 16'h7C00);
    wait_el(6119);
    check("R6 one before trip", cnt, 16'h7CFE);
    check("R6 request low before", wdts, 1'b0);
    check("R7 flag low before", prio, 1'b0);
    wait_el(6120);
    check("R6 trip count", cnt, 16'h7CFF);
    check("R6 request high", wdts, 1'b1);
    check("R7 flag sets", prio, 1'b1);
    wait_el(6144);
    check("R6 count moved", cnt, 16'h7D00);
    check("R6 request drops", wdts, 1'b0);
    check("R7 flag sticky", prio, 1'b1);

    // R8 window edge and R9 expiry
    write_rel(8'h15);
    refresh(12);
    cyc_r = cyc; base_l = 16'h1500;
    check("R8 reload d=12", cnt, 16'h1500);
    write_rel(8'h33);
    refresh(13);
    check("R9 no reload d=13", cnt, fast_model(base_l, cyc - cyc_r));
    pulse_go();
    check("R9 step discarded", cnt, fast_model(base_l, cyc - cyc_r));

    // R11: prescaler restart
    refresh(1);
    cyc_r = cyc;
    check("R8 reload d=1", cnt, 16'h3300);
    wait_el(23);
    check("R11 no early step", cnt, 16'h3300);
    wait_el(24);
    check("R11 full period", cnt, 16'h3301);

    // R4 / R13: slow prescaler
    write_rel(8'h91);
    refresh(2);
    cyc_r = cyc;
    check("R13 reload slow", cnt, 16'h1100);
    wait_el(383);
    check("R4 before slow step", cnt, 16'h1100);
    wait_el(384);
    check("R4 slow step", cnt, 16'h1101);
    wait_el(768);
    check("R4 second slow step", cnt, 16'h1102);

    // random refresh timing
    for (int i = 0; i < 24; i++) begin
      logic [7:0] ra, rb;
      int gap, d;
      ra = 8'($urandom % 128);
      rb = 8'($urandom % 128);
      gap = int'($urandom % 20);
      d = 1 + int'($urandom % 16);
      write_rel(ra);
      refresh(1);
      cyc_r = cyc; base_l = img(ra);
      check("R8 random align", cnt, img(ra));
      write_rel(rb);
      repeat (gap) @(negedge clk);
      refresh(d);
      if (d <= 12) begin
        check("R8 random in window", cnt, img(rb));
      end else begin
        check("R9 random late go", cnt, fast_model(base_l, cyc - cyc_r));
        pulse_go();
        check("R10 random lone go", cnt, fast_model(base_l, cyc - cyc_r));
      end
      check("R6 random no request", wdts, (cnt == 16'h7CFF));
    end

    // R12: wrap on the fast copy
    w_rel_we = 1'b1; w_rel_wd = 8'h7F;
    @(negedge clk);
    w_rel_we = 1'b0; w_go = 1'b1;
    @(negedge clk);
    w_go = 1'b0; w_arm = 1'b1;
    @(negedge clk);
    w_arm = 1'b0; w_go = 1'b1;
    @(negedge clk);
    w_go = 1'b0;
    cyc_r = cyc;
    check("R8 fast copy reload", w_cnt, 16'h7F00);
    wait_el(2 * 32'h80FF);
    check("R12 top value", w_cnt, 16'hFFFF);
    wait_el(2 * 32'h80FF + 2);
    check("R12 wraps to zero", w_cnt, 16'h0000);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule